// File: doc/BRIEF.md
# Dual-Width Flash Bus Front End

This block is the host-facing side of a small NOR flash array. On every system clock it samples the active-low chip-enable, output-enable, write-enable and hardware-reset controls. From them it decodes a read, a write, standby, output disable or reset. A width-select input switches the data path between 16-bit words and 8-bit bytes. In byte mode the top data input pin acts as the lowest address bit and picks the byte lane of the addressed word. Read data and the two lane output enables are registered. A testbench or pad ring uses them to drive tri-state buffers for the low and high byte lanes.

When the identifier input is high, reads return identification codes instead of array data. Address bits 6, 1 and 0 pick the code. It can be the manufacturer code, the device code for the selected boot layout, or the protection status of the sector named by address bits 18..12. Writes made in identifier mode with the protection-status pattern set or clear the protection bit of the addressed sector. Ordinary writes produce a one-cycle bus strobe with the latched address and data. Unless the target sector is protected, they also update the array. The array is a reduced-depth word store that the word and byte views share.

Top module: `flash_bus_front`

## Requirements
- R1: A word-mode read (chip enable 0, output enable 0, write enable 1, reset 1, width-select 1, identifier 0) drives `dataOut` with the word at array index `addrIn[MEM_AW-1:0]` and raises both lane enables, one clock after the inputs are sampled.
- R2: In byte mode (width-select 0), `dataIn[15]` selects the lane: 1 selects bits 15..8 of the word and 0 selects bits 7..0. The selected byte appears on `dataOut[7:0]`, `dataOut[15:8]` is 0, and only `loLaneOe` is raised.
- R3: When output enable or chip enable is high at a sampled edge, both lane enables are 0 and `dataOut` is 0 after that edge.
- R4: While reset is low, the lane enables, `wrStrobe` and `dataOut` clear, all protection bits clear, and bus writes leave the array unchanged.
- R5: A write (chip enable 0, output enable 1, write enable 0) raises `wrStrobe` for the following cycle. `wrAddr` is `{addrIn, lane}`, where the lane bit is 0 in word mode. `wrData` is the full word in word mode and `{8'h00, dataIn[7:0]}` in byte mode. A word write replaces the array word; a byte write replaces only the selected lane.
- R6: An identifier read with address bits {6,1,0} = 000 returns 0001h, or 01h in byte mode.
- R7: An identifier read with {6,1,0} = 001 returns the device code. For the top-boot layout (the default) this is 22EAh in word mode and EAh in byte mode. For the bottom-boot layout it is 226Bh and 6Bh.
- R8: An identifier read with {6,1,0} = 010 returns 0001h if the sector addressed by bits 18..12 is protected and 0000h if it is not.
- R9: An identifier-mode write with {6,1,0} = 010 sets that sector's protection bit to `dataIn[0]` and leaves the array unchanged.
- R10: Address bits 18..12 map to 19 sectors in the top-boot layout. Values 0000xxx to 1110xxx select sectors 0 to 14 by their upper four bits. 11110xx selects sector 15, 1111100 selects 16, 1111101 selects 17, and 111111x selects 18.
- R11: A write to a protected sector still raises `wrStrobe` but leaves the array word unchanged.
- R12: Any other control pattern, including output enable and write enable both low, is neither a read nor a write. Identifier reads with any other {6,1,0} value return 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all bus inputs are sampled on its rising edge |
| busResetN | input | 1 | Hardware reset, active low |
| chipEnN | input | 1 | Chip enable, active low |
| outEnN | input | 1 | Output enable, active low |
| writeEnN | input | 1 | Write enable, active low |
| wideMode | input | 1 | 1 = 16-bit word mode, 0 = 8-bit byte mode |
| idMode | input | 1 | 1 = reads return identifier and protection codes |
| addrIn | input | ADDR_W (19) | Word address bits 18..0 |
| dataIn | input | 16 | Write data; bit 15 is the byte-lane address in byte mode |
| dataOut | output | 16 | Registered read data |
| loLaneOe | output | 1 | Drive enable for data bits 7..0 |
| hiLaneOe | output | 1 | Drive enable for data bits 15..8 |
| wrStrobe | output | 1 | One-cycle pulse per accepted bus write |
| wrAddr | output | ADDR_W+1 (20) | Latched byte address of the last write |
| wrData | output | 16 | Latched data of the last write |

## Verification
The embedded assertions check properties that hold on every cycle. The high lane is never enabled without the low lane. Output-enable or chip-enable high always turns both lanes off after the next edge. Byte-mode reads leave the upper byte at zero. Reset clears the outputs and the protection bits. Every decoded write produces a strobe, and writes to a protected sector or in identifier mode leave the addressed array word as it was. Some behaviours only the bench's scenarios can show, because it checks them against its own behavioural model on every clock. These are: the correct array word and lane for a given address, the exact identifier codes, the sector boundaries of the top-boot decode, and protection surviving across many other bus cycles until a reset clears it.

// File: rtl/flash_bus_pkg.sv
package flash_bus_pkg;

  // Identifier selector values on address bits {6,1,0}
  localparam logic [2:0] ID_MANUF  = 3'b000;
  localparam logic [2:0] ID_DEVICE = 3'b001;
  localparam logic [2:0] ID_PROT   = 3'b010;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic       rdArr;     // array read this cycle
    logic       rdId;      // identifier read this cycle
    logic       wrArr;     // array write request this cycle
    logic       wrId;      // identifier-mode write this cycle
    logic       byteMode;  // 8-bit view
    logic       laneSel;   // byte lane (1 = upper) in byte mode
    logic [2:0] idSel;     // address bits {6,1,0}
  } busStrobes_t;

  // Top-boot sector number from address bits 18..12
  function automatic logic [4:0] topSector(input logic [6:0] hi);
    logic [4:0] s;
    if (hi[6:3] != 4'b1111)      s = {1'b0, hi[6:3]};
    else if (!hi[2])             s = 5'd15;
    else if (hi[1:0] == 2'b00)   s = 5'd16;
    else if (hi[1:0] == 2'b01)   s = 5'd17;
    else                         s = 5'd18;
    return s;
  endfunction

endpackage

// File: rtl/fbf_ctrl.sv
module fbf_ctrl
  import flash_bus_pkg::*;
(
  input  logic        clk,
  input  logic        busResetN,
  input  logic        chipEnN,
  input  logic        outEnN,
  input  logic        writeEnN,
  input  logic        wideMode,
  input  logic        idMode,
  input  logic [2:0]  idBits,
  input  logic        laneBit,
  output busStrobes_t strobes,
  output logic        loLaneOe,
  output logic        hiLaneOe
);

  logic isRead;
  logic isWrite;

  assign isRead  = busResetN && !chipEnN && !outEnN &&  writeEnN;
  assign isWrite = busResetN && !chipEnN &&  outEnN && !writeEnN;

  always_comb begin
    strobes.rdArr    = isRead  && !idMode;
    strobes.rdId     = isRead  &&  idMode;
    strobes.wrArr    = isWrite && !idMode;
    strobes.wrId     = isWrite &&  idMode;
    strobes.byteMode = !wideMode;
    strobes.laneSel  = !wideMode && laneBit;
    strobes.idSel    = idBits;
  end

  always_ff @(posedge clk) begin
    if (!busResetN) begin
      loLaneOe <= 1'b0;
      hiLaneOe <= 1'b0;
    end else begin
      loLaneOe <= isRead;
      hiLaneOe <= isRead && wideMode;
    end
  end

  AST_HI_NEEDS_LO: assert property (@(posedge clk) disable iff (!busResetN)
    hiLaneOe |-> loLaneOe); // R2

  AST_OE_OFF_QUIET: assert property (@(posedge clk) disable iff (!busResetN)
    (outEnN || chipEnN) |=> (!loLaneOe && !hiLaneOe)); // R3

endmodule

// File: rtl/fbf_datapath.sv
module fbf_datapath
  import flash_bus_pkg::*;
#(
  parameter int  ADDR_W      = 19,
  parameter int  MEM_AW      = 6,
  parameter int  NUM_SECTORS = 19,
  parameter bit  TOP_BOOT    = 1'b1
) (
  input  logic              clk,
  input  logic              busResetN,
  input  busStrobes_t       strobes,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [15:0]       dataIn,
  output logic [15:0]       dataOut,
  output logic              wrStrobe,
  output logic [ADDR_W:0]   wrAddr,
  output logic [15:0]       wrData
);

  localparam int DEPTH = 1 << MEM_AW;
  localparam int SEC_W = $clog2(NUM_SECTORS);
  localparam logic [7:0] DEV_HI = 8'h22;
  localparam logic [7:0] DEV_LO = TOP_BOOT ? 8'hEA : 8'h6B;

  logic [15:0]            mem [DEPTH];
  logic [NUM_SECTORS-1:0] protBits;
  logic [MEM_AW-1:0]      idx;
  logic [SEC_W-1:0]       sec;
  logic                   secProt;
  logic [15:0]            word;
  logic [15:0]            arrVal;
  logic [15:0]            idVal;
  logic                   arrWrite;

  assign idx      = addrIn[MEM_AW-1:0];
  assign sec      = SEC_W'(topSector(addrIn[ADDR_W-1 -: 7]));
  assign secProt  = protBits[sec];
  assign word     = mem[idx];
  assign arrWrite = strobes.wrArr && !secProt;

  always_comb begin
    if (strobes.byteMode)
      arrVal = {8'h00, strobes.laneSel ? word[15:8] : word[7:0]};
    else
      arrVal = word;
  end

  always_comb begin
    case (strobes.idSel)
      ID_MANUF:  idVal = 16'h0001;
      ID_DEVICE: idVal = strobes.byteMode ? {8'h00, DEV_LO} : {DEV_HI, DEV_LO};
      ID_PROT:   idVal = {15'h0000, secProt};
      default:   idVal = 16'h0000;
    endcase
  end

  // Array storage: word and byte views share it
  always_ff @(posedge clk) begin
    if (busResetN && arrWrite) begin
      if (!strobes.byteMode)
        mem[idx] <= dataIn;
      else if (strobes.laneSel)
        mem[idx][15:8] <= dataIn[7:0];
      else
        mem[idx][7:0] <= dataIn[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!busResetN) begin
      dataOut  <= '0;
      wrStrobe <= 1'b0;
      wrAddr   <= '0;
      wrData   <= '0;
      protBits <= '0;
    end else begin
      dataOut  <= strobes.rdId ? idVal : (strobes.rdArr ? arrVal : 16'h0000);
      wrStrobe <= strobes.wrArr || strobes.wrId;
      if (strobes.wrArr || strobes.wrId) begin
        wrAddr <= {addrIn, strobes.laneSel};
        wrData <= strobes.byteMode ? {8'h00, dataIn[7:0]} : dataIn;
      end
      if (strobes.wrId && strobes.idSel == ID_PROT)
        protBits[sec] <= dataIn[0];
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !busResetN |=> (!wrStrobe && dataOut == 16'h0000 && protBits == '0)); // R4

  AST_BYTE_HIGH_ZERO: assert property (@(posedge clk) disable iff (!busResetN)
    (strobes.byteMode && (strobes.rdArr || strobes.rdId)) |=> dataOut[15:8] == 8'h00); // R2

  AST_WRITE_STROBES: assert property (@(posedge clk) disable iff (!busResetN)
    (strobes.wrArr || strobes.wrId) |=> wrStrobe); // R5

  AST_PROT_HOLDS: assert property (@(posedge clk) disable iff (!busResetN)
    ((strobes.wrArr && secProt) || strobes.wrId) |=> mem[$past(idx)] === $past(word)); // R11

endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
  import flash_bus_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int MEM_AW      = 6,
  parameter int NUM_SECTORS = 19,
  parameter bit TOP_BOOT    = 1'b1
) (
  input  logic              clk,
  input  logic              busResetN,
  input  logic              chipEnN,
  input  logic              outEnN,
  input  logic              writeEnN,
  input  logic              wideMode,
  input  logic              idMode,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [15:0]       dataIn,
  output logic [15:0]       dataOut,
  output logic              loLaneOe,
  output logic              hiLaneOe,
  output logic              wrStrobe,
  output logic [ADDR_W:0]   wrAddr,
  output logic [15:0]       wrData
);

  busStrobes_t strobes;

  fbf_ctrl u_ctrl (
    .clk       (clk),
    .busResetN (busResetN),
    .chipEnN   (chipEnN),
    .outEnN    (outEnN),
    .writeEnN  (writeEnN),
    .wideMode  (wideMode),
    .idMode    (idMode),
    .idBits    ({addrIn[6], addrIn[1], addrIn[0]}),
    .laneBit   (dataIn[15]),
    .strobes   (strobes),
    .loLaneOe  (loLaneOe),
    .hiLaneOe  (hiLaneOe)
  );

  fbf_datapath #(
    .ADDR_W      (ADDR_W),
    .MEM_AW      (MEM_AW),
    .NUM_SECTORS (NUM_SECTORS),
    .TOP_BOOT    (TOP_BOOT)
  ) u_dp (
    .clk       (clk),
    .busResetN (busResetN),
    .strobes   (strobes),
    .addrIn    (addrIn),
    .dataIn    (dataIn),
    .dataOut   (dataOut),
    .wrStrobe  (wrStrobe),
    .wrAddr    (wrAddr),
    .wrData    (wrData)
  );

endmodule

// File: tb/tb_flash_bus_front.sv
module tb_flash_bus_front;

  logic        clk = 1'b0;
  logic        busResetN, chipEnN, outEnN, writeEnN, wideMode, idMode;
  logic [18:0] addrIn;
  logic [15:0] dataIn;
  logic [15:0] dataOut;
  logic        loLaneOe, hiLaneOe, wrStrobe;
  logic [19:0] wrAddr;
  logic [15:0] wrData;

  flash_bus_front dut (
    .clk(clk), .busResetN(busResetN), .chipEnN(chipEnN), .outEnN(outEnN),
    .writeEnN(writeEnN), .wideMode(wideMode), .idMode(idMode),
    .addrIn(addrIn), .dataIn(dataIn), .dataOut(dataOut),
    .loLaneOe(loLaneOe), .hiLaneOe(hiLaneOe), .wrStrobe(wrStrobe),
    .wrAddr(wrAddr), .wrData(wrData)
  );

  always #10 clk = ~clk;  // 50 MHz

  int    checks = 0;
  int    failures = 0;
  bit    finished = 0;
  string curReq = "R4";

  // Behavioural reference model
  logic [15:0] mMem [64];
  bit          kLo [64];
  bit          kHi [64];
  bit          mProt [19];
  bit          eLo, eHi, eWs, eKnown;
  logic [15:0] eData, eWd;
  logic [19:0] eWa;

  initial begin
    for (int i = 0; i < 64; i++) begin kLo[i] = 0; kHi[i] = 0; mMem[i] = 0; end
    for (int i = 0; i < 19; i++) mProt[i] = 0;
    eLo = 0; eHi = 0; eWs = 0; eKnown = 0; eData = 0; eWd = 0; eWa = 0;
  end

  function automatic int secOf(input logic [18:0] a);
    int v;
    v = int'(a >> 12);
    if (v < 120)       return v / 8;
    else if (v < 124)  return 15;
    else if (v == 124) return 16;
    else if (v == 125) return 17;
    else               return 18;
  endfunction

  always @(posedge clk) begin
    bit rd, wr, lsb;
    int ix, sc, sel;
    rd  = busResetN && !chipEnN && !outEnN && writeEnN;
    wr  = busResetN && !chipEnN && outEnN && !writeEnN;
    lsb = !wideMode && dataIn[15];
    ix  = int'(addrIn[5:0]);
    sc  = secOf(addrIn);
    sel = {addrIn[6], addrIn[1], addrIn[0]};
    if (!busResetN) begin
      eLo = 0; eHi = 0; eWs = 0; eData = 0; eKnown = 1;
      for (int i = 0; i < 19; i++) mProt[i] = 0;
    end else begin
      eLo = rd; eHi = rd && wideMode;
      eData = 0; eKnown = 1;
      if (rd && idMode) begin
        if (sel == 0)      eData = 16'h0001;
        else if (sel == 1) eData = wideMode ? 16'h22EA : 16'h00EA;
        else if (sel == 2) eData = mProt[sc] ? 16'h0001 : 16'h0000;
        else               eData = 16'h0000;
      end else if (rd) begin
        if (wideMode) begin eData = mMem[ix]; eKnown = kLo[ix] && kHi[ix]; end
        else if (lsb) begin eData = {8'h00, mMem[ix][15:8]}; eKnown = kHi[ix]; end
        else          begin eData = {8'h00, mMem[ix][7:0]};  eKnown = kLo[ix]; end
      end
      eWs = wr;
      if (wr) begin
        eWa = {addrIn, lsb};
        eWd = wideMode ? dataIn : {8'h00, dataIn[7:0]};
        if (idMode) begin
          if (sel == 2) mProt[sc] = dataIn[0];
        end else if (!mProt[sc]) begin
          if (wideMode) begin mMem[ix] = dataIn; kLo[ix] = 1; kHi[ix] = 1; end
          else if (lsb) begin mMem[ix][15:8] = dataIn[7:0]; kHi[ix] = 1; end
          else          begin mMem[ix][7:0]  = dataIn[7:0]; kLo[ix] = 1; end
        end
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", curReq, what, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    chk("loLaneOe", 32'(loLaneOe), 32'(eLo));
    chk("hiLaneOe", 32'(hiLaneOe), 32'(eHi));
    chk("wrStrobe", 32'(wrStrobe), 32'(eWs));
    if (eKnown) chk("dataOut", 32'(dataOut), 32'(eData));
    if (eWs) begin
      chk("wrAddr", 32'(wrAddr), 32'(eWa));
      chk("wrData", 32'(wrData), 32'(eWd));
    end
  endtask

  task automatic busOp(input bit ce, input bit oe, input bit we, input bit wide,
                       input bit id, input logic [18:0] a, input logic [15:0] d);
    chipEnN = ce; outEnN = oe; writeEnN = we; wideMode = wide; idMode = id;
    addrIn = a; dataIn = d;
    tick();
  endtask

  task automatic idle();                                   busOp(1,1,1,1,0,19'h0,16'h0); endtask
  task automatic rdW(input logic [18:0] a);                busOp(0,0,1,1,0,a,16'h0); endtask
  task automatic wrW(input logic [18:0] a, input logic [15:0] d); busOp(0,1,0,1,0,a,d); endtask
  task automatic rdB(input logic [18:0] a, input bit l);   busOp(0,0,1,0,0,a,{l,15'h0}); endtask
  task automatic wrB(input logic [18:0] a, input bit l, input logic [7:0] b); busOp(0,1,0,0,0,a,{l,7'h0,b}); endtask
  task automatic idRd(input logic [18:0] a, input bit wide); busOp(0,0,1,wide,1,a,16'h0); endtask
  task automatic idWr(input logic [18:0] a, input bit v);  busOp(0,1,0,1,1,a,{15'h0,v}); endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    busResetN = 0;
    chipEnN = 1; outEnN = 1; writeEnN = 1; wideMode = 1; idMode = 0;
    addrIn = '0; dataIn = '0;
    curReq = "R4";
    repeat (3) tick();
    busResetN = 1;
    idle();

    // R5 / R1: word writes then read back
    curReq = "R5";
    for (int i = 0; i < 8; i++) wrW(19'(i), 16'(16'hA500 + i * 16'h0111));
    idle();
    curReq = "R1";
    for (int i = 0; i < 8; i++) rdW(19'(7 - i));
    rdW(19'h00040 | 19'h3);  // aliases to index 3
    idle();

    // R2: byte views of the same storage, lane write
    curReq = "R2";
    rdB(19'h2, 1'b0); rdB(19'h2, 1'b1); rdB(19'h5, 1'b1);
    wrB(19'h4, 1'b1, 8'h3C); rdW(19'h4);
    wrB(19'h9, 1'b0, 8'h5A); wrB(19'h9, 1'b1, 8'hC3); rdW(19'h9); rdB(19'h9, 1'b1);
    idle();

    // R3: output enable or chip enable high
    curReq = "R3";
    busOp(0,1,1,1,0,19'h1,16'h0); busOp(1,0,1,1,0,19'h1,16'h0);
    busOp(1,1,0,1,0,19'h1,16'hFFFF); rdW(19'h1);

    // R12: both strobes low, and unused identifier codes
    curReq = "R12";
    busOp(0,0,0,1,0,19'h1,16'h1234); rdW(19'h1);
    idRd(19'h00003, 1'b1); idRd(19'h00040, 1'b1); idRd(19'h00042, 1'b1);
    idle();

    // R6 / R7: manufacturer and device codes in both widths
    curReq = "R6";
    idRd(19'h0, 1'b1); idRd(19'h0, 1'b0);
    curReq = "R7";
    idRd(19'h1, 1'b1); idRd(19'h1, 1'b0); idRd(19'h7FF01, 1'b1);
    idle();

    // R9 / R8: protect sector 15 and read its status
    curReq = "R9";
    idWr(19'h78002, 1'b1); rdW(19'h2);
    curReq = "R8";
    idRd(19'h78002, 1'b1); idRd(19'h7B002, 1'b0); idRd(19'h77002, 1'b1); idRd(19'h7C002, 1'b1);

    // R11: writes into the protected sector are blocked, others land
    curReq = "R11";
    wrW(19'h79006, 16'hDEAD); rdW(19'h6);
    wrB(19'h7A006, 1'b1, 8'h11); rdW(19'h6);
    wrW(19'h10006, 16'hBEEF); rdW(19'h6);
    idle();

    // R10: sector boundaries near the top of the map
    curReq = "R10";
    idWr(19'h7C002, 1'b1);
    idRd(19'h7C002, 1'b1); idRd(19'h7D002, 1'b1); idRd(19'h7E002, 1'b1);
    idWr(19'h7F002, 1'b1);
    idRd(19'h7E002, 1'b1); idRd(19'h7D002, 1'b1);
    idWr(19'h18002, 1'b1);
    idRd(19'h1F002, 1'b1); idRd(19'h20002, 1'b1); idRd(19'h17002, 1'b1);
    idWr(19'h7C002, 1'b0); idRd(19'h7C002, 1'b1);
    idle();

    // R4: reset during a write: no array change, protection cleared
    curReq = "R4";
    chipEnN = 0; outEnN = 1; writeEnN = 0; wideMode = 1; idMode = 0;
    addrIn = 19'h00007; dataIn = 16'h0BAD; busResetN = 0;
    tick(); tick();
    busResetN = 1;
    idle();
    rdW(19'h7);
    idRd(19'h78002, 1'b1); idRd(19'h7F002, 1'b1);
    wrW(19'h79008, 16'h7777); rdW(19'h8);
    idle(); idle();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule